// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction in every clock cycle, with no pipeline. It holds a program counter, a word-organised instruction store, a 32-entry register file, an arithmetic unit, a data store and the steering multiplexers. A main decoder turns the opcode into datapath controls. A second decoder turns the function code of register-to-register instructions into an arithmetic operation.

The supported subset has three instruction groups. Register-to-register arithmetic covers add, subtract, AND, OR and signed set-less-than. There are word loads and word stores that use a base register plus a signed 16-bit offset. There is a conditional branch that is taken when two registers are equal, tested on the zero flag of their difference. Both stores are filled through a preload port while reset is held. A retirement trace (PC, fetched word, register-file write, data-store write) shows the effect of every instruction at the ports.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 and all 32 registers become 0; the first instruction after reset is fetched from byte address 0.
- R2: For every instruction other than a taken branch, the next PC is the current PC plus 4. Addresses are byte addresses and instructions are 32-bit words.
- R3: Opcode 0 (bits 31:26) is register-to-register. The function code in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). The first operand is the register named in bits 25:21, the second is the one in bits 20:16, and the result is written to the register named in bits 15:11.
- R4: Opcode 35 loads a word. It reads the data store at the first-operand register plus the sign-extended bits 15:0, and writes the word to the register named in bits 20:16. Negative offsets must work.
- R5: Opcode 43 stores a word. It writes the register named in bits 20:16 to the data store at the first-operand register plus the sign-extended offset, and writes no register.
- R6: Opcode 4 with equal operand registers is a taken branch. The next PC is PC + 4 + (sign-extended offset × 4), forward or backward.
- R7: Opcode 4 with unequal operands goes to PC + 4 and writes neither a register nor the data store.
- R8: Register 0 always reads as 0. A write aimed at it is dropped and is not reported on the trace.
- R9: The preload port writes the instruction store (`boot_to_dmem` = 0) or the data store (`boot_to_dmem` = 1) at word `boot_addr[..:2]`, and only while `rst_n` is low. While running, it has no effect.
- R10: An unknown opcode, or opcode 0 with an unlisted function code, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_we | input | 1 | Preload write strobe (honoured only in reset) |
| boot_to_dmem | input | 1 | Preload target: 0 instruction store, 1 data store |
| boot_addr | input | 32 | Preload byte address |
| boot_wdata | input | 32 | Preload word |
| pc_o | output | 32 | Address of the instruction retiring this cycle |
| instr_o | output | 32 | Instruction word retiring this cycle |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written to the register |
| dm_we_o | output | 1 | A data-store write commits at the next edge |
| dm_addr_o | output | 32 | Byte address of the data-store write |
| dm_wdata_o | output | 32 | Word written to the data store |

## Verification
The first program is an arithmetic sweep. It loads every ordered pair drawn from zero, one, all-ones, the largest positive and the most negative word, then runs all five operations on each pair. This separates carry and borrow handling, signed from unsigned comparison, and the logic operations from the arithmetic ones. The preload strobe is held active throughout this run, so any write that leaks in shows up in a later load. The second program mixes writes to register 0, a negative load offset, taken and untaken branches, a backward branch that forms a loop, and an unknown opcode. Against a reference model stepped in the bench, this exposes wrong register steering, wrong branch arithmetic and stray writes.

// File: rtl/sc_core_pkg.sv
// Package sc_core_pkg: shared constants, opcodes, operation codes and the
// control bundle for the single-cycle core. Assumes a 32-bit data width.
package sc_core_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    typedef enum logic [5:0] {
        OPC_REG   = 6'd0,
        OPC_BEQ   = 6'd4,
        OPC_LOAD  = 6'd35,
        OPC_STORE = 6'd43
    } opcode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_SLT
    } alu_op_e;

    // Class of arithmetic work requested by the main decoder
    typedef enum logic [1:0] {
        CLS_ADDR,
        CLS_CMP,
        CLS_FUNCT,
        CLS_IDLE
    } alu_cls_e;

    typedef struct packed {
        logic     reg_write;
        logic     dst_is_rd;
        logic     src_is_imm;
        logic     wb_from_mem;
        logic     mem_write;
        logic     branch;
        alu_cls_e alu_cls;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
// Module sc_main_dec: maps the 6-bit opcode onto datapath controls.
// Assumes unknown opcodes must leave all architectural state untouched.
module sc_main_dec
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    // Opcode to control bundle
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, src_is_imm: 1'b0,
                 wb_from_mem: 1'b0, mem_write: 1'b0, branch: 1'b0,
                 alu_cls: CLS_IDLE};
        case (opcode)
            OPC_REG: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.alu_cls   = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.reg_write   = 1'b1;
                ctrl.src_is_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.alu_cls     = CLS_ADDR;
            end
            OPC_STORE: begin
                ctrl.src_is_imm = 1'b1;
                ctrl.mem_write  = 1'b1;
                ctrl.alu_cls    = CLS_ADDR;
            end
            OPC_BEQ: begin
                ctrl.branch  = 1'b1;
                ctrl.alu_cls = CLS_CMP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
// Module sc_alu_dec: picks the arithmetic operation from the decoder class
// and, for register-register work, from the function code. funct_ok is low
// when an unlisted function code arrives, so the top can suppress the write.
module sc_alu_dec
    import sc_core_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_op_e    op,
    output logic       funct_ok
);

    // Class and function code to operation
    always_comb begin
        op       = OP_ADD;
        funct_ok = 1'b1;
        case (cls)
            CLS_ADDR: op = OP_ADD;
            CLS_CMP:  op = OP_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  op = OP_ADD;
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_SLT:  op = OP_SLT;
                    default: funct_ok = 1'b0;
                endcase
            end
            default: op = OP_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// Module sc_alu: combinational arithmetic unit with a zero flag.
// Assumes two's-complement operands; set-less-than compares signed.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    // Operation select
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    // Zero flag used by the branch comparison
    assign zero = (y == '0);

endmodule

// File: rtl/sc_regbank.sv
// Module sc_regbank: register file with two combinational read ports and
// one write port committed at the rising edge. Entry 0 is never written
// and reads as zero. A synchronous reset clears every entry.
module sc_regbank
    import sc_core_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int W     = XLEN,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    logic [W-1:0] regs [NREGS];

    // Storage update: clear on reset, else commit non-zero-index writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports with entry 0 forced to zero
    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata))); // R3

    AST_ZERO_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0) |=> (regs[0] == '0)); // R8

endmodule

// File: rtl/sc_core.sv
// Module sc_core: single-cycle processor top. Holds the PC, the instruction
// and data stores, the steering multiplexers and the sub-blocks. Assumes
// both stores are filled through the preload port while rst_n is low, and
// that word addresses wrap within each store.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_we,
    input  logic            boot_to_dmem,
    input  logic [XLEN-1:0] boot_addr,
    input  logic [XLEN-1:0] boot_wdata,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] instr_o,
    output logic            rf_we_o,
    output logic [RIDX-1:0] rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            dm_we_o,
    output logic [XLEN-1:0] dm_addr_o,
    output logic [XLEN-1:0] dm_wdata_o
);

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [5:0]      f_opc;
    logic [RIDX-1:0] f_rs;
    logic [RIDX-1:0] f_rt;
    logic [RIDX-1:0] f_rd;
    logic [5:0]      f_fn;
    logic [XLEN-1:0] imm_ext;

    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic            funct_ok;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] mem_rdata;
    logic [DAW-1:0]  dm_idx;
    logic [RIDX-1:0] dst;
    logic [XLEN-1:0] wb_data;
    logic            rf_we_req;
    logic            take_branch;

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    // Instruction store: preload writes only during reset
    always_ff @(posedge clk) begin
        if (!rst_n && boot_we && !boot_to_dmem)
            imem[boot_addr[IAW+1:2]] <= boot_wdata;
    end

    // Fetch and field split
    assign instr   = imem[pc[IAW+1:2]];
    assign f_opc   = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_fn    = instr[5:0];
    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_main_dec u_main_dec (
        .opcode (f_opc),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .cls      (ctrl.alu_cls),
        .funct    (f_fn),
        .op       (alu_op),
        .funct_ok (funct_ok)
    );

    // Destination, second operand and write-back steering
    assign dst       = ctrl.dst_is_rd   ? f_rd    : f_rt;
    assign alu_b     = ctrl.src_is_imm  ? imm_ext : rt_val;
    assign wb_data   = ctrl.wb_from_mem ? mem_rdata : alu_y;
    assign rf_we_req = ctrl.reg_write & funct_ok;

    sc_regbank #(
        .NREGS (32),
        .W     (XLEN)
    ) u_regbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .we      (rf_we_req),
        .waddr   (dst),
        .wdata   (wb_data)
    );

    sc_alu #(
        .W (XLEN)
    ) u_alu (
        .op   (alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store: preload during reset, core stores while running
    assign dm_idx    = alu_y[DAW+1:2];
    assign mem_rdata = dmem[dm_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (boot_we && boot_to_dmem)
                dmem[boot_addr[DAW+1:2]] <= boot_wdata;
        end else if (ctrl.mem_write) begin
            dmem[dm_idx] <= rt_val;
        end
    end

    // Next-PC selection
    assign pc_plus4    = pc + 32'd4;
    assign take_branch = ctrl.branch & alu_zero;
    assign pc_next     = take_branch ? (pc_plus4 + {imm_ext[XLEN-3:0], 2'b00})
                                     : pc_plus4;

    // Retirement trace
    assign pc_o       = pc;
    assign instr_o    = instr;
    assign rf_we_o    = rf_we_req && (dst != '0);
    assign rf_waddr_o = dst;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = ctrl.mem_write;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    logic unused_bits;
    assign unused_bits = ^{boot_addr[XLEN-1:IAW+2], boot_addr[1:0],
                           pc[XLEN-1:IAW+2], pc[1:0], instr[10:6]};

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00); // R2

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.branch && alu_zero) |=> (pc == $past(pc) + 32'd4)); // R2

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.branch && alu_zero)
        |=> (pc == $past(pc) + 32'd4 + {$past(imm_ext[XLEN-3:0]), 2'b00})); // R6

    AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> !rf_we_o); // R5

    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |=> (dmem[$past(dm_idx)] == $past(rt_val))); // R5

    AST_BRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.branch |-> (!rf_we_o && !dm_we_o)); // R7

endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
// Bench for sc_core: runs two programs against an instruction-level model
// stepped in the bench and compares the retirement trace every cycle.
module test_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_we = 1'b0;
    logic        boot_to_dmem = 1'b0;
    logic [31:0] boot_addr = '0;
    logic [31:0] boot_wdata = '0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o;
    logic [4:0]  rf_waddr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] m_im [256];
    logic [31:0] m_dm [64];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;

    always #4 clk = ~clk;

    sc_core i_sc_core (
        .clk (clk), .rst_n (rst_n),
        .boot_we (boot_we), .boot_to_dmem (boot_to_dmem),
        .boot_addr (boot_addr), .boot_wdata (boot_wdata),
        .pc_o (pc_o), .instr_o (instr_o),
        .rf_we_o (rf_we_o), .rf_waddr_o (rf_waddr_o), .rf_wdata_o (rf_wdata_o),
        .dm_we_o (dm_we_o), .dm_addr_o (dm_addr_o), .dm_wdata_o (dm_wdata_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    // Preload both stores while reset is held, then release reset
    task automatic boot_and_start();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            boot_we = 1'b1; boot_to_dmem = 1'b0;
            boot_addr = i * 4; boot_wdata = m_im[i];
        end
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            boot_we = 1'b1; boot_to_dmem = 1'b1;
            boot_addr = i * 4; boot_wdata = m_dm[i];
        end
        @(negedge clk);
        boot_we = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_pc = '0;
        rst_n = 1'b1;
        #1;
        chk("R1 pc after reset", pc_o, 32'd0);
    endtask

    // Step the model one instruction per cycle and compare the trace
    task automatic run(input int ncyc, input string ld_tag);
        string pc_tag = "R1 first fetch";
        for (int c = 0; c < ncyc; c++) begin
            logic [31:0] ins, a, b, sx, res, npc, addr;
            logic [5:0]  op, fn;
            int          rs, rt, rd;
            logic        ewe, edwe, ok;
            logic [4:0]  ewa;
            logic [31:0] ewd;
            string       tag;
            ins = m_im[m_pc[9:2]];
            op = ins[31:26]; fn = ins[5:0];
            rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
            sx = {{16{ins[15]}}, ins[15:0]};
            a = m_rf[rs]; b = m_rf[rt];
            ewe = 1'b0; edwe = 1'b0; ewa = '0; ewd = '0; addr = a + sx;
            npc = m_pc + 32'd4;
            tag = "R10";
            if (op == 6'd0) begin
                ok = 1'b1; res = '0;
                case (fn)
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h2A: res = {31'd0, $signed(a) < $signed(b)};
                    default: ok = 1'b0;
                endcase
                if (ok) begin
                    tag = (rd == 0) ? "R8" : "R3";
                    ewe = (rd != 0); ewa = rd[4:0]; ewd = res;
                end
            end else if (op == 6'd35) begin
                tag = (rt == 0) ? "R8" : ld_tag;
                ewe = (rt != 0); ewa = rt[4:0]; ewd = m_dm[addr[7:2]];
            end else if (op == 6'd43) begin
                tag = (rt == 0) ? "R8 store" : "R5";
                edwe = 1'b1;
            end else if (op == 6'd4) begin
                tag = "R7";
                if (a == b) begin
                    tag = "R6";
                    npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
                end
            end
            chk(pc_tag, pc_o, m_pc);
            chk({tag, " reg write enable"}, {31'd0, rf_we_o}, {31'd0, ewe});
            if (ewe) begin
                chk({tag, " reg index"}, {27'd0, rf_waddr_o}, {27'd0, ewa});
                chk({tag, " reg value"}, rf_wdata_o, ewd);
            end
            chk({tag, " store enable"}, {31'd0, dm_we_o}, {31'd0, edwe});
            if (edwe) begin
                chk({tag, " store address"}, dm_addr_o, addr);
                chk({tag, " store data"}, dm_wdata_o, b);
            end
            if (ewe) m_rf[ewa] = ewd;
            if (edwe) m_dm[addr[7:2]] = b;
            pc_tag = (op == 6'd4 && a == b) ? "R6 branch target" : "R2 next pc";
            m_pc = npc;
            @(negedge clk);
        end
    endtask

    initial begin
        int pos;
        logic [31:0] vals [5];
        vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000;

        // Program 1: every operand pair through all five operations
        for (int i = 0; i < 256; i++) m_im[i] = '0;
        for (int i = 0; i < 64; i++)  m_dm[i] = 32'h1000 + i;
        for (int i = 0; i < 5; i++)   m_dm[i] = vals[i];
        pos = 0;
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                m_im[pos] = enc_i(6'd35, 0, 1, 4 * i);   pos++;
                m_im[pos] = enc_i(6'd35, 0, 2, 4 * j);   pos++;
                m_im[pos] = enc_r(1, 2, 3, 6'h20);       pos++;
                m_im[pos] = enc_r(1, 2, 4, 6'h22);       pos++;
                m_im[pos] = enc_r(1, 2, 5, 6'h24);       pos++;
                m_im[pos] = enc_r(1, 2, 6, 6'h25);       pos++;
                m_im[pos] = enc_r(1, 2, 7, 6'h2A);       pos++;
            end
        end
        m_im[pos] = enc_i(6'd43, 0, 7, 40); pos++;
        m_im[pos] = enc_i(6'd43, 0, 3, 44); pos++;
        boot_and_start();
        // R9: preload strobe held active while running must change nothing
        boot_we = 1'b1; boot_to_dmem = 1'b1; boot_addr = 32'd0; boot_wdata = 32'hDEAD_BEEF;
        run(pos + 4, "R4/R9");
        boot_we = 1'b0;

        // Program 2: register 0, negative offsets, branches, unknown opcode
        for (int i = 0; i < 256; i++) m_im[i] = '0;
        for (int i = 0; i < 64; i++)  m_dm[i] = 32'h2000 + i;
        m_dm[0] = 32'd7; m_dm[1] = 32'd7; m_dm[3] = 32'd20;
        m_im[0]  = enc_i(6'd35, 0, 1, 0);
        m_im[1]  = enc_i(6'd35, 0, 2, 4);
        m_im[2]  = enc_i(6'd35, 0, 8, 12);
        m_im[3]  = enc_r(1, 2, 0, 6'h20);        // R8 write to register 0
        m_im[4]  = enc_i(6'd43, 0, 0, 8);        // R8 store register 0
        m_im[5]  = enc_i(6'd35, 8, 9, -8);       // R4 negative offset
        m_im[6]  = enc_i(6'd4, 1, 2, 2);         // R6 taken forward
        m_im[7]  = enc_r(1, 1, 10, 6'h20);
        m_im[8]  = enc_r(1, 1, 11, 6'h20);
        m_im[9]  = enc_i(6'd4, 1, 3, 5);         // R7 untaken, r3 cleared by R1
        m_im[10] = enc_i(6'd43, 8, 1, -4);       // R5 negative offset
        m_im[11] = {6'd63, 26'h123_4567};        // R10 unknown opcode
        m_im[12] = enc_r(1, 2, 12, 6'h22);
        m_im[13] = enc_i(6'd4, 12, 0, -5);       // R6 backward
        m_im[14] = enc_r(1, 2, 13, 6'h3F);       // R10 unlisted funct
        boot_and_start();
        run(40, "R4");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule